// File: doc/BRIEF.md
# Conversion Result Averaging and Window Compare Unit

This block sits between an analog-to-digital converter and the result store. Raw conversion codes arrive on a valid/ready sample stream. The block can sum a burst of 4, 8, 16 or 32 consecutive samples and reduce the sum to one rounded mean. While a burst is under way it holds a request line high so that the sequencer starts further conversions. The block then subtracts a signed correction value and clamps the difference to the converter's code range.

The corrected value is tested against one or two signed thresholds. The test can check below a limit, above a limit, outside a window, or inside a window. For the two window tests, the sense of the window reverses when the first threshold is the larger one. A value that fails an enabled test is dropped. A value that passes, or any value when the test is off, leaves on a valid/ready result stream.

Back-pressure works as follows. A result stays on the output with its data frozen until the consumer takes it. While a result is held, the sample input deasserts ready, so the whole two-stage path stalls as one unit. Configuration inputs are plain levels. They must not change while a value is between the averaging stage and the output, except for the average code, which is captured once at the start of each burst.

Top module: `avgcmp_top`

## Requirements
- R1: Average code 0, 1, 2 and 3 combines 4, 8, 16 and 32 accepted samples into one result. Codes 4 to 7 turn averaging off, and each sample then yields its own result.
- R2: A burst of N samples yields (sum + N/2) / N, rounded down, which is half-up rounding of the mean.
- R3: `conv_req` is high from the cycle after the first sample of a multi-sample burst is accepted until the edge that accepts the burst's last sample. It stays low whenever averaging is off.
- R4: The average code is captured when a burst's first sample is accepted. Changes to it during the burst have no effect on that burst.
- R5: The result is the mean minus the signed 16-bit `offset`, clamped to 0 and 2^RES_W-1 instead of wrapping.
- R6: With compare on, mode 0 keeps a value only if it is below `thr_a`, and mode 1 keeps it only if it is above `thr_a`. The thresholds are signed 16-bit, and the value is compared as a non-negative number.
- R7: Mode 2 with `thr_a` <= `thr_b` keeps values below `thr_a` or above `thr_b`. With `thr_a` > `thr_b` it keeps values strictly between `thr_b` and `thr_a`.
- R8: Mode 3 with `thr_a` <= `thr_b` keeps values from `thr_a` to `thr_b` inclusive. With `thr_a` > `thr_b` it keeps values at or above `thr_a`, or at or below `thr_b`.
- R9: With `cmp_en` low every result is delivered. With it high, a failing result never raises `res_valid`.
- R10: `smp_ready` equals `!res_valid || res_ready`. A held result keeps `res_valid` high and `res_data` unchanged until `res_ready`.
- R11: Without a stall, `res_valid` rises two clock edges after the edge that accepts the sample completing a result.
- R12: During reset, `res_valid` and `conv_req` are low and `smp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Raw sample offered |
| smp_ready | output | 1 | Sample accepted on this edge when valid |
| smp_data | input | RES_W | Raw conversion code |
| avg_code | input | 3 | Burst length select (0..3 averaging, 4..7 off) |
| offset | input | 16 | Signed correction subtracted from the mean |
| cmp_en | input | 1 | Enables the threshold test |
| cmp_mode | input | 2 | 0 below, 1 above, 2 outside, 3 inside |
| thr_a | input | 16 | Signed first threshold |
| thr_b | input | 16 | Signed second threshold |
| conv_req | output | 1 | Asks the sequencer for another conversion |
| res_valid | output | 1 | Result available (done strobe) |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | RES_W | Corrected, filtered result |

## Verification
A result is due two edges after the edge that accepts its final sample, one edge for the averaging register and one for the output register. A stalled output pushes this out by the number of edges in which `res_ready` is low. The bench drives inputs just after the rising edge and compares every output at the falling edge against a behavioural model. That model advances its own state only on the edges where it predicts an advance. This way each check of `res_valid`, `res_data`, `conv_req` and `smp_ready` looks at the exact cycle in which the requirements say the value must hold. Random back-pressure exercises the stalled paths.

// File: rtl/avgcmp_pkg.sv
`timescale 1ns/1ps
package avgcmp_pkg;
  localparam int MAX_SHIFT = 5;

  typedef enum logic [1:0] {
    CMP_BELOW   = 2'd0,
    CMP_ABOVE   = 2'd1,
    CMP_OUTSIDE = 2'd2,
    CMP_INSIDE  = 2'd3
  } cmp_mode_e;

  // log2 of the burst length for a given average code; 0 means single sample
  function automatic logic [2:0] avg_shift(input logic [2:0] code);
    return (code <= 3'd3) ? code + 3'd2 : 3'd0;
  endfunction
endpackage

// File: rtl/avgcmp_accum.sv
`timescale 1ns/1ps
module avgcmp_accum
  import avgcmp_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             take,
  input  logic [RES_W-1:0] smp,
  input  logic [2:0]       avg_code,
  output logic             avg_valid,
  output logic [RES_W-1:0] avg_data,
  output logic             busy
);
  localparam int SUM_W = RES_W + MAX_SHIFT + 1;
  localparam int CNT_W = MAX_SHIFT;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum_q;
  logic [2:0]       shift_q;

  logic [2:0]       shift_eff;
  logic [CNT_W:0]   span;
  logic [SUM_W-1:0] sum_nxt;
  logic [SUM_W-1:0] rounded;
  logic             last;

  always_comb begin
    shift_eff = (cnt_q == '0) ? avg_shift(avg_code) : shift_q;
    span      = (CNT_W+1)'(1) << shift_eff;
    sum_nxt   = ((cnt_q == '0) ? '0 : sum_q) + SUM_W'(smp);
    last      = ({1'b0, cnt_q} == (span - (CNT_W+1)'(1)));
    rounded   = (sum_nxt + SUM_W'(span >> 1)) >> shift_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sum_q     <= '0;
      shift_q   <= '0;
      avg_valid <= 1'b0;
      avg_data  <= '0;
    end else if (adv) begin
      avg_valid <= take && last;
      if (take) begin
        sum_q <= sum_nxt;
        if (cnt_q == '0) shift_q <= shift_eff;
        if (last) begin
          cnt_q    <= '0;
          avg_data <= rounded[RES_W-1:0];
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/avgcmp_offset.sv
`timescale 1ns/1ps
module avgcmp_offset #(
  parameter int RES_W = 12
) (
  input  logic [RES_W-1:0] avg,
  input  logic [15:0]      offset,
  output logic [RES_W-1:0] corrected
);
  localparam int DW = ((RES_W > 16) ? RES_W : 16) + 2;
  localparam logic signed [DW-1:0] TOP = DW'((64'd1 << RES_W) - 64'd1);

  logic signed [DW-1:0] a_s, o_s, diff;

  always_comb begin
    a_s  = $signed({{(DW-RES_W){1'b0}}, avg});
    o_s  = $signed({{(DW-16){offset[15]}}, offset});
    diff = a_s - o_s;
    if (diff < 0)        corrected = '0;
    else if (diff > TOP) corrected = TOP[RES_W-1:0];
    else                 corrected = diff[RES_W-1:0];
  end
endmodule

// File: rtl/avgcmp_window.sv
`timescale 1ns/1ps
module avgcmp_window
  import avgcmp_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic [RES_W-1:0] x,
  input  logic [1:0]       mode,
  input  logic [15:0]      thr_a,
  input  logic [15:0]      thr_b,
  output logic             pass
);
  localparam int CW = ((RES_W > 16) ? RES_W : 16) + 1;

  logic signed [CW-1:0] xs, as, bs;
  logic a_le_b, lt_a, gt_a, lt_b, gt_b;

  always_comb begin
    xs     = $signed({{(CW-RES_W){1'b0}}, x});
    as     = $signed({{(CW-16){thr_a[15]}}, thr_a});
    bs     = $signed({{(CW-16){thr_b[15]}}, thr_b});
    a_le_b = (as <= bs);
    lt_a   = (xs < as);
    gt_a   = (xs > as);
    lt_b   = (xs < bs);
    gt_b   = (xs > bs);
    unique case (cmp_mode_e'(mode))
      CMP_BELOW:   pass = lt_a;
      CMP_ABOVE:   pass = gt_a;
      CMP_OUTSIDE: pass = a_le_b ? (lt_a || gt_b) : (lt_a && gt_b);
      CMP_INSIDE:  pass = a_le_b ? (!lt_a && !gt_b) : (!lt_a || !gt_b);
      default:     pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/avgcmp_top.sv
`timescale 1ns/1ps
module avgcmp_top #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [RES_W-1:0] smp_data,
  input  logic [2:0]       avg_code,
  input  logic [15:0]      offset,
  input  logic             cmp_en,
  input  logic [1:0]       cmp_mode,
  input  logic [15:0]      thr_a,
  input  logic [15:0]      thr_b,
  output logic             conv_req,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_data
);
  logic             adv, take;
  logic             avg_valid;
  logic [RES_W-1:0] avg_data, corrected;
  logic             pass;

  assign adv       = !res_valid || res_ready;
  assign take      = smp_valid && adv;
  assign smp_ready = adv;

  avgcmp_accum #(.RES_W(RES_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .take(take), .smp(smp_data),
    .avg_code(avg_code), .avg_valid(avg_valid), .avg_data(avg_data),
    .busy(conv_req)
  );

  avgcmp_offset #(.RES_W(RES_W)) offset_i (
    .avg(avg_data), .offset(offset), .corrected(corrected)
  );

  avgcmp_window #(.RES_W(RES_W)) window_i (
    .x(corrected), .mode(cmp_mode), .thr_a(thr_a), .thr_b(thr_b), .pass(pass)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (adv) begin
      res_valid <= avg_valid && (!cmp_en || pass);
      if (avg_valid && (!cmp_en || pass)) res_data <= corrected;
    end
  end
endmodule

// File: rtl/avgcmp_sva.sv
`timescale 1ns/1ps
module avgcmp_sva #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic             cmp_en,
  input logic [1:0]       cmp_mode,
  input logic [15:0]      thr_a,
  input logic             conv_req,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_data
);
  localparam int CW = ((RES_W > 16) ? RES_W : 16) + 1;
  logic signed [CW-1:0] xs, as;
  assign xs = $signed({{(CW-RES_W){1'b0}}, res_data});
  assign as = $signed({{(CW-16){thr_a[15]}}, thr_a});

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !smp_ready);

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(smp_valid && smp_ready, 2));

  assert_below_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cmp_en && cmp_mode == 2'd0 |-> xs < as);

  assert_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cmp_en && cmp_mode == 2'd1 |-> xs > as);

  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_req) |-> $past(smp_valid && smp_ready));
endmodule

bind avgcmp_top avgcmp_sva #(.RES_W(RES_W)) sva_i (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .cmp_en(cmp_en), .cmp_mode(cmp_mode), .thr_a(thr_a), .conv_req(conv_req),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
);

// File: tb/avgcmp_top_tb_top.sv
`timescale 1ns/1ps
module avgcmp_top_tb_top;
  localparam int RES_W = 12;
  localparam int MAXV  = (1 << RES_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             smp_valid = 1'b0;
  logic             smp_ready;
  logic [RES_W-1:0] smp_data = '0;
  logic [2:0]       avg_code = 3'd4;
  logic [15:0]      offset = '0;
  logic             cmp_en = 1'b0;
  logic [1:0]       cmp_mode = 2'd0;
  logic [15:0]      thr_a = '0;
  logic [15:0]      thr_b = '0;
  logic             conv_req;
  logic             res_valid;
  logic             res_ready = 1'b1;
  logic [RES_W-1:0] res_data;

  always #4 clk = ~clk;  // 125 MHz

  avgcmp_top #(.RES_W(RES_W)) dut_i (.*);

  int    vectors = 0;
  int    errors  = 0;
  string cur_req = "R12";
  bit    bp_on   = 1'b0;
  bit    done    = 1'b0;

  // behavioural reference state
  int m_cnt, m_sum, m_sh, m_s1d, m_od;
  bit m_s1v, m_ov;

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  function automatic int shift_of(input int code);
    return (code < 4) ? code + 2 : 0;
  endfunction

  function automatic int correct(input int avg);
    int d;
    d = avg - int'($signed(offset));
    if (d < 0) d = 0;
    if (d > MAXV) d = MAXV;
    return d;
  endfunction

  function automatic bit keeps(input int x);
    int a, b;
    a = int'($signed(thr_a));
    b = int'($signed(thr_b));
    case (cmp_mode)
      2'd0: return x < a;
      2'd1: return x > a;
      2'd2: return (a <= b) ? (x < a || x > b) : (x < a && x > b);
      default: return (a <= b) ? (x >= a && x <= b) : (x >= a || x <= b);
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sum = 0; m_sh = 0; m_s1d = 0; m_od = 0; m_s1v = 0; m_ov = 0;
    end else begin
      bit adv, nv;
      int sh, avg;
      vectors++;
      if (res_valid !== m_ov) fail(cur_req, "res_valid", int'(res_valid), int'(m_ov));
      else if (m_ov && res_data !== RES_W'(m_od)) fail(cur_req, "res_data", int'(res_data), m_od);
      if (conv_req !== (m_cnt != 0)) fail("R3", "conv_req", int'(conv_req), int'(m_cnt != 0));
      if (smp_ready !== (!m_ov || res_ready)) fail("R10", "smp_ready", int'(smp_ready), int'(!m_ov || res_ready));
      adv = !m_ov || res_ready;
      if (adv) begin
        nv = m_s1v && (!cmp_en || keeps(m_s1d));
        if (nv) m_od = m_s1d;
        m_ov  = nv;
        m_s1v = 1'b0;
        if (smp_valid) begin
          sh = (m_cnt == 0) ? shift_of(int'(avg_code)) : m_sh;
          if (m_cnt == 0) begin m_sh = sh; m_sum = 0; end
          m_sum += int'(smp_data);
          if (m_cnt == (1 << sh) - 1) begin
            avg   = (m_sum + ((1 << sh) >> 1)) >> sh;
            m_s1d = correct(avg);
            m_s1v = 1'b1;
            m_cnt = 0;
          end else m_cnt++;
        end
      end
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    res_ready = bp_on ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  // all tasks start and end just after a rising edge
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send(input int v);
    smp_valid = 1'b1;
    smp_data  = RES_W'(v);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic drain();
    bp_on = 1'b0;
    idle(8);
  endtask

  task automatic set_cmp(input bit en, input int mode, input int a, input int b);
    cmp_en = en; cmp_mode = 2'(mode); thr_a = 16'(a); thr_b = 16'(b);
  endtask

  initial begin
    idle(4);
    // R12: outputs during reset
    vectors += 3;
    if (res_valid !== 1'b0) fail("R12", "res_valid", int'(res_valid), 0);
    if (conv_req  !== 1'b0) fail("R12", "conv_req", int'(conv_req), 0);
    if (smp_ready !== 1'b1) fail("R12", "smp_ready", int'(smp_ready), 1);
    rst_n = 1'b1;
    idle(2);

    // R11 / R9: single samples, no averaging, compare off
    cur_req = "R11";
    send(123); idle(4);
    send(7); send(4095); send(0); send(2048); drain();

    // R9: compare on with mode 0 and threshold 0 discards everything
    cur_req = "R9";
    set_cmp(1'b0, 0, 0, 0);
    send(10); send(20);
    drain();
    set_cmp(1'b1, 0, 0, 0);
    send(10); send(20); send(0);
    drain();
    set_cmp(1'b0, 0, 0, 0);

    // R1: each burst length
    cur_req = "R1";
    for (int c = 0; c < 4; c++) begin
      avg_code = 3'(c);
      for (int i = 0; i < (4 << c); i++) send((i * 97 + c * 311) % 4096);
      drain();
    end
    avg_code = 3'd7;
    send(55); send(66); drain();

    // R2: rounding of the mean
    cur_req = "R2";
    avg_code = 3'd0;
    send(1); send(1); send(1); send(0);
    send(1); send(0); send(0); send(0);
    send(4095); send(4095); send(4095); send(4094);
    drain();

    // R4: average code change mid-burst is ignored
    cur_req = "R4";
    avg_code = 3'd0;
    send(100);
    avg_code = 3'd3;
    send(200); send(300); send(400);
    idle(3);
    avg_code = 3'd4;
    send(9);
    drain();

    // R3: gapped samples inside a burst of 16
    cur_req = "R3";
    avg_code = 3'd2;
    for (int i = 0; i < 16; i++) begin send(i * 200); idle(i % 3); end
    drain();
    avg_code = 3'd4;

    // R5: offset and clamping
    cur_req = "R5";
    offset = 16'd100;    send(50); send(100); send(1000); drain();
    offset = -16'sd300;  send(4000); send(3000); drain();
    offset = 16'h8000;   send(0); drain();
    offset = 16'h7FFF;   send(4095); drain();
    offset = 16'd0;

    // R6: below and above a single threshold
    cur_req = "R6";
    set_cmp(1'b1, 0, 2000, 0);
    send(1999); send(2000); send(2001); send(0); drain();
    set_cmp(1'b1, 1, 2000, 0);
    send(1999); send(2000); send(2001); send(4095); drain();
    set_cmp(1'b1, 1, -5, 0);
    send(0); send(17); drain();

    // R7: outside window, both threshold orders
    cur_req = "R7";
    set_cmp(1'b1, 2, 1000, 3000);
    send(999); send(1000); send(2000); send(3000); send(3001); drain();
    set_cmp(1'b1, 2, 3000, 1000);
    send(999); send(1000); send(1001); send(2999); send(3000); send(3001); drain();

    // R8: inside window, both threshold orders
    cur_req = "R8";
    set_cmp(1'b1, 3, 1000, 3000);
    send(999); send(1000); send(2000); send(3000); send(3001); drain();
    set_cmp(1'b1, 3, 3000, 1000);
    send(999); send(1000); send(1001); send(2999); send(3000); send(3001); drain();

    // R10: random back-pressure with averaging and window compare
    cur_req = "R10";
    set_cmp(1'b1, 3, 0, 3500);
    bp_on = 1'b1;
    avg_code = 3'd1;
    for (int i = 0; i < 64; i++) send(int'($urandom % 4096));
    avg_code = 3'd4;
    for (int i = 0; i < 64; i++) send(int'($urandom % 4096));
    drain();

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule